// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block runs the bus cycles of a 16-bit processor whose low address bits and data share one set of pins, with a 20-bit address. A client offers a transfer on a simple request port: address, write data, a memory-or-I/O flag, a direction bit, a high-byte enable, a segment code and the interrupt-enable flag that is reported as status. The block then steps through the fixed clock states T1, T2, T3 and T4. It puts the address and the data on the shared lines one after the other and phases the latch strobe, the read and write strobes, the buffer enable and the direction line from one state to the next.

The shared lines are modelled as three signals: a driven value, an output enable and a sampled input. A slow target holds READY low to stretch the cycle by whole clocks between T2 and T3. At the end of the cycle, read data comes back together with a one-clock completion pulse. After reset, the block fetches from the restart address 0xFFFF0 without any request. It takes a new request only when it is idle or in T4, so cycles can run back to back with no gap.

Top module: `mbus_cycle_seq`

## Requirements
- R1: While `rst` is high, `ale`, `ad_oe`, `done` and `req_ready` are 0, and `rd_n`, `wr_n`, `den_n` and `bhe_n` are 1.
- R2: After reset is released, the block runs a memory read at 0xFFFF0 with no request. This fetch has segment code 10 and interrupt flag 0. `req_ready` stays 0 until that fetch reaches T4.
- R3: In T1, `ale` is 1 for exactly one clock. `ad_oe` is 1, `ad_out` carries address bits 15..0, `a_hi` carries address bits 19..16, `mio` equals the memory flag (1 = memory) and `dtr` equals the direction (1 = write). `rd_n`, `wr_n` and `den_n` are 1 in T1.
- R4: In T2, in every wait state and in T3, `den_n` is 0. A read drives `rd_n` to 0 and leaves `wr_n` at 1 and `ad_oe` at 0. A write drives `wr_n` to 0, leaves `rd_n` at 1, sets `ad_oe` to 1 and places the write data on `ad_out`.
- R5: From T2 through T4, `a_hi` carries status. Bit 3 is 0, bit 2 is the request's interrupt flag, and bits 1..0 are the segment code (00 extra, 01 stack, 10 code or none, 11 data).
- R6: READY is sampled at the clock edge that ends T2 and at the edge that ends each wait state. When it is low, one more wait state follows with the strobes held, so a cycle with N low samples lasts 4+N clocks.
- R7: `ad_in` is sampled at the edge that ends T3. It appears on `rdata` while `done` is 1, and `done` lasts exactly one clock, during T4. `done` also pulses for writes, and a write leaves `rdata` unchanged.
- R8: In T4, `rd_n`, `wr_n` and `den_n` are 1 and `ad_oe` and `ale` are 0.
- R9: `req_ready` is 1 only in idle and in T4. A request offered in T4 starts T1 on the next clock. A `req_valid` pulse while `req_ready` is 0 starts no cycle. Request fields are held internally from acceptance, so later changes on the request inputs do not affect the running cycle.
- R10: `bhe_n` is the inverse of the high-byte enable from T1 through T4, and is 1 when idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request taken at this edge if valid |
| req_addr | input | 20 | Transfer address |
| req_wdata | input | 16 | Write data |
| req_mem | input | 1 | 1 = memory, 0 = I/O |
| req_write | input | 1 | 1 = write, 0 = read |
| req_hi_en | input | 1 | Upper data byte takes part |
| req_seg | input | 2 | Segment code reported as status |
| req_int_en | input | 1 | Interrupt-enable flag reported as status |
| ad_out | output | 16 | Value driven on the shared address/data lines |
| ad_oe | output | 1 | Shared lines driven when 1 |
| ad_in | input | 16 | Value sampled from the shared lines |
| a_hi | output | 4 | Upper address in T1, status afterwards |
| ale | output | 1 | Address latch strobe |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| mio | output | 1 | 1 = memory cycle |
| dtr | output | 1 | 1 = transmit (write), 0 = receive |
| den_n | output | 1 | Data buffer enable, active low |
| bhe_n | output | 1 | High byte enable, active low |
| ready | input | 1 | Target ready; low inserts wait states |
| rdata | output | 16 | Read data |
| done | output | 1 | One-clock completion pulse |

## Verification
Two things can land on the same clock edge: the completion of one cycle in T4, with its read data and `done` pulse, and the acceptance of the next request, which starts T1 on the following clock. The bench provokes this by offering each new request in the T4 of the previous one. It then checks that the first cycle's data and `done` are intact while the second cycle's address phase begins one clock later. It also offers a stray request during T2 of a stretched cycle, where it must be ignored and READY alone decides the wait count. Wait counts, directions, segments and addresses are otherwise drawn at random with a fixed seed.

// File: rtl/mbus_pkg.sv
package mbus_pkg;
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_T1   = 3'd1,
    PH_T2   = 3'd2,
    PH_TW   = 3'd3,
    PH_T3   = 3'd4,
    PH_T4   = 3'd5
  } phase_e;

  localparam logic [1:0] SEG_EXTRA = 2'b00;
  localparam logic [1:0] SEG_STACK = 2'b01;
  localparam logic [1:0] SEG_CODE  = 2'b10;
  localparam logic [1:0] SEG_DATA  = 2'b11;
endpackage

// File: rtl/mbus_phase_fsm.sv
module mbus_phase_fsm
  import mbus_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   req_valid,
  input  logic   ready,
  output phase_e st,
  output phase_e st_nxt,
  output logic   take_boot,
  output logic   take_req,
  output logic   req_ready
);
  logic boot_pend;

  always_comb begin
    st_nxt    = st;
    take_boot = 1'b0;
    take_req  = 1'b0;
    unique case (st)
      PH_IDLE: begin
        if (boot_pend) begin
          st_nxt    = PH_T1;
          take_boot = 1'b1;
        end else if (req_valid) begin
          st_nxt   = PH_T1;
          take_req = 1'b1;
        end
      end
      PH_T1: st_nxt = PH_T2;
      PH_T2, PH_TW: st_nxt = ready ? PH_T3 : PH_TW;
      PH_T3: st_nxt = PH_T4;
      PH_T4: begin
        if (req_valid) begin
          st_nxt   = PH_T1;
          take_req = 1'b1;
        end else begin
          st_nxt = PH_IDLE;
        end
      end
      default: st_nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= PH_IDLE;
      boot_pend <= 1'b1;
    end else begin
      st <= st_nxt;
      if (take_boot) boot_pend <= 1'b0;
    end
  end

  assign req_ready = ((st == PH_IDLE) || (st == PH_T4)) && !boot_pend;

  // R6: a low READY sample at the end of T2 or Tw yields another wait state
  a_r6_wait_inserted: assert property (@(posedge clk) disable iff (rst)
    ((st == PH_T2 || st == PH_TW) && !ready) |=> (st == PH_TW));
  // R6: a high READY sample leaves the wait state for T3
  a_r6_wait_exit: assert property (@(posedge clk) disable iff (rst)
    (st == PH_TW && ready) |=> (st == PH_T3));
  // R9: T4 with a request offered goes straight to T1
  a_r9_back_to_back: assert property (@(posedge clk) disable iff (rst)
    (st == PH_T4 && req_valid) |=> (st == PH_T1));
endmodule

// File: rtl/mbus_req_hold.sv
module mbus_req_hold
  import mbus_pkg::*;
#(
  parameter int          AW        = 20,
  parameter int          DW        = 16,
  parameter logic [AW-1:0] RESET_VEC = 20'hFFFF0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          take_boot,
  input  logic          take_req,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic          req_mem,
  input  logic          req_write,
  input  logic          req_hi_en,
  input  logic [1:0]    req_seg,
  input  logic          req_int_en,
  output logic [AW-1:0] nxt_addr,
  output logic [DW-1:0] nxt_wdata,
  output logic          nxt_mem,
  output logic          nxt_write,
  output logic          nxt_hi,
  output logic [1:0]    nxt_seg,
  output logic          nxt_ie
);
  logic [AW-1:0] cur_addr;
  logic [DW-1:0] cur_wdata;
  logic          cur_mem, cur_write, cur_hi, cur_ie;
  logic [1:0]    cur_seg;

  always_comb begin
    if (take_boot) begin
      nxt_addr  = RESET_VEC;
      nxt_wdata = '0;
      nxt_mem   = 1'b1;
      nxt_write = 1'b0;
      nxt_hi    = 1'b1;
      nxt_seg   = SEG_CODE;
      nxt_ie    = 1'b0;
    end else if (take_req) begin
      nxt_addr  = req_addr;
      nxt_wdata = req_wdata;
      nxt_mem   = req_mem;
      nxt_write = req_write;
      nxt_hi    = req_hi_en;
      nxt_seg   = req_seg;
      nxt_ie    = req_int_en;
    end else begin
      nxt_addr  = cur_addr;
      nxt_wdata = cur_wdata;
      nxt_mem   = cur_mem;
      nxt_write = cur_write;
      nxt_hi    = cur_hi;
      nxt_seg   = cur_seg;
      nxt_ie    = cur_ie;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_addr  <= '0;
      cur_wdata <= '0;
      cur_mem   <= 1'b0;
      cur_write <= 1'b0;
      cur_hi    <= 1'b0;
      cur_seg   <= SEG_EXTRA;
      cur_ie    <= 1'b0;
    end else begin
      cur_addr  <= nxt_addr;
      cur_wdata <= nxt_wdata;
      cur_mem   <= nxt_mem;
      cur_write <= nxt_write;
      cur_hi    <= nxt_hi;
      cur_seg   <= nxt_seg;
      cur_ie    <= nxt_ie;
    end
  end

  // R9: held fields only change on an acceptance
  a_r9_fields_held: assert property (@(posedge clk) disable iff (rst)
    (!take_boot && !take_req) |=> $stable(cur_addr) && $stable(cur_write));
endmodule

// File: rtl/mbus_pin_drive.sv
module mbus_pin_drive
  import mbus_pkg::*;
#(
  parameter int AW = 20,
  parameter int DW = 16,
  localparam int HW = AW - DW
) (
  input  logic          clk,
  input  logic          rst,
  input  phase_e        st,
  input  phase_e        st_nxt,
  input  logic [AW-1:0] nxt_addr,
  input  logic [DW-1:0] nxt_wdata,
  input  logic          nxt_mem,
  input  logic          nxt_write,
  input  logic          nxt_hi,
  input  logic [1:0]    nxt_seg,
  input  logic          nxt_ie,
  input  logic [DW-1:0] ad_in,
  output logic [DW-1:0] ad_out,
  output logic          ad_oe,
  output logic [HW-1:0] a_hi,
  output logic          ale,
  output logic          rd_n,
  output logic          wr_n,
  output logic          mio,
  output logic          dtr,
  output logic          den_n,
  output logic          bhe_n,
  output logic [DW-1:0] rdata,
  output logic          done
);
  logic          addr_ph, data_ph, stat_ph, busy;
  logic [HW-1:0] status;

  always_comb begin
    addr_ph = (st_nxt == PH_T1);
    data_ph = (st_nxt == PH_T2) || (st_nxt == PH_TW) || (st_nxt == PH_T3);
    stat_ph = data_ph || (st_nxt == PH_T4);
    busy    = (st_nxt != PH_IDLE);
    status  = {{(HW-3){1'b0}}, nxt_ie, nxt_seg};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ad_out <= '0;
      ad_oe  <= 1'b0;
      a_hi   <= '0;
      ale    <= 1'b0;
      rd_n   <= 1'b1;
      wr_n   <= 1'b1;
      mio    <= 1'b0;
      dtr    <= 1'b0;
      den_n  <= 1'b1;
      bhe_n  <= 1'b1;
      rdata  <= '0;
      done   <= 1'b0;
    end else begin
      ale   <= addr_ph;
      ad_oe <= addr_ph || (data_ph && nxt_write);
      if (addr_ph)                    ad_out <= nxt_addr[DW-1:0];
      else if (data_ph && nxt_write)  ad_out <= nxt_wdata;
      else                            ad_out <= '0;
      if (addr_ph)      a_hi <= nxt_addr[AW-1:DW];
      else if (stat_ph) a_hi <= status;
      else              a_hi <= '0;
      rd_n  <= !(data_ph && !nxt_write);
      wr_n  <= !(data_ph && nxt_write);
      den_n <= !data_ph;
      mio   <= busy && nxt_mem;
      dtr   <= busy && nxt_write;
      bhe_n <= !(busy && nxt_hi);
      done  <= (st == PH_T3);
      if (st == PH_T3 && !nxt_write) rdata <= ad_in;
    end
  end

  // R1: one clock after a reset sample the pins are quiet
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!ale && !ad_oe && !done && rd_n && wr_n && den_n && bhe_n));
  // R3: the latch strobe never lasts two clocks
  a_r3_ale_single: assert property (@(posedge clk) disable iff (rst)
    ale |=> !ale);
  // R4: read and write strobes are never low together
  a_r4_one_strobe: assert property (@(posedge clk) disable iff (rst)
    !(!rd_n && !wr_n));
  // R4: the shared lines float while the read strobe is low
  a_r4_read_floats: assert property (@(posedge clk) disable iff (rst)
    !rd_n |-> !ad_oe);
  // R5: the top status bit is 0 whenever the buffers are enabled
  a_r5_top_status_low: assert property (@(posedge clk) disable iff (rst)
    !den_n |-> !a_hi[HW-1]);
  // R7: the completion pulse is one clock long
  a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R8: in T4 strobes are released and the lines float
  a_r8_t4_released: assert property (@(posedge clk) disable iff (rst)
    done |-> (rd_n && wr_n && den_n && !ad_oe && !ale));
endmodule

// File: rtl/mbus_cycle_seq.sv
module mbus_cycle_seq
  import mbus_pkg::*;
#(
  parameter int            AW        = 20,
  parameter int            DW        = 16,
  parameter logic [AW-1:0] RESET_VEC = 20'hFFFF0,
  localparam int           HW        = AW - DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic          req_mem,
  input  logic          req_write,
  input  logic          req_hi_en,
  input  logic [1:0]    req_seg,
  input  logic          req_int_en,
  output logic [DW-1:0] ad_out,
  output logic          ad_oe,
  input  logic [DW-1:0] ad_in,
  output logic [HW-1:0] a_hi,
  output logic          ale,
  output logic          rd_n,
  output logic          wr_n,
  output logic          mio,
  output logic          dtr,
  output logic          den_n,
  output logic          bhe_n,
  input  logic          ready,
  output logic [DW-1:0] rdata,
  output logic          done
);
  phase_e        st, st_nxt;
  logic          take_boot, take_req;
  logic [AW-1:0] nxt_addr;
  logic [DW-1:0] nxt_wdata;
  logic          nxt_mem, nxt_write, nxt_hi, nxt_ie;
  logic [1:0]    nxt_seg;

  mbus_phase_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .ready     (ready),
    .st        (st),
    .st_nxt    (st_nxt),
    .take_boot (take_boot),
    .take_req  (take_req),
    .req_ready (req_ready)
  );

  mbus_req_hold #(.AW(AW), .DW(DW), .RESET_VEC(RESET_VEC)) u_hold (
    .clk        (clk),
    .rst        (rst),
    .take_boot  (take_boot),
    .take_req   (take_req),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .req_mem    (req_mem),
    .req_write  (req_write),
    .req_hi_en  (req_hi_en),
    .req_seg    (req_seg),
    .req_int_en (req_int_en),
    .nxt_addr   (nxt_addr),
    .nxt_wdata  (nxt_wdata),
    .nxt_mem    (nxt_mem),
    .nxt_write  (nxt_write),
    .nxt_hi     (nxt_hi),
    .nxt_seg    (nxt_seg),
    .nxt_ie     (nxt_ie)
  );

  mbus_pin_drive #(.AW(AW), .DW(DW)) u_pins (
    .clk       (clk),
    .rst       (rst),
    .st        (st),
    .st_nxt    (st_nxt),
    .nxt_addr  (nxt_addr),
    .nxt_wdata (nxt_wdata),
    .nxt_mem   (nxt_mem),
    .nxt_write (nxt_write),
    .nxt_hi    (nxt_hi),
    .nxt_seg   (nxt_seg),
    .nxt_ie    (nxt_ie),
    .ad_in     (ad_in),
    .ad_out    (ad_out),
    .ad_oe     (ad_oe),
    .a_hi      (a_hi),
    .ale       (ale),
    .rd_n      (rd_n),
    .wr_n      (wr_n),
    .mio       (mio),
    .dtr       (dtr),
    .den_n     (den_n),
    .bhe_n     (bhe_n),
    .rdata     (rdata),
    .done      (done)
  );

  // R9: no request is taken in the clock after the address phase
  a_r9_busy_after_ale: assert property (@(posedge clk) disable iff (rst)
    ale |=> !req_ready);
endmodule

// File: tb/mbus_cycle_seq_tb_top.sv
module mbus_cycle_seq_tb_top;
  localparam int AW = 20;
  localparam int DW = 16;
  localparam int HW = AW - DW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          req_mem = 1'b0, req_write = 1'b0, req_hi_en = 1'b0, req_int_en = 1'b0;
  logic [1:0]    req_seg = 2'b00;
  logic [DW-1:0] ad_out, ad_in = '0, rdata;
  logic          ad_oe, ale, rd_n, wr_n, mio, dtr, den_n, bhe_n, done;
  logic          ready = 1'b1;
  logic [HW-1:0] a_hi;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;
  logic [DW-1:0] last_rdata = '0;

  always #2.5 clk = ~clk;

  mbus_cycle_seq dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_mem(req_mem),
    .req_write(req_write), .req_hi_en(req_hi_en), .req_seg(req_seg),
    .req_int_en(req_int_en), .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in),
    .a_hi(a_hi), .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .mio(mio), .dtr(dtr),
    .den_n(den_n), .bhe_n(bhe_n), .ready(ready), .rdata(rdata), .done(done)
  );

  task automatic eq(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [HW-1:0] status_of(logic [1:0] seg, logic ie);
    return {1'b0, ie, seg};
  endfunction

  task automatic scramble_req();
    req_addr   = AW'($urandom);
    req_wdata  = DW'($urandom);
    req_mem    = 1'($urandom);
    req_write  = 1'($urandom);
    req_hi_en  = 1'($urandom);
    req_seg    = 2'($urandom);
    req_int_en = 1'($urandom);
  endtask

  task automatic check_data(string tag, bit wr, logic [DW-1:0] wd, bit hi,
                            logic [1:0] seg, bit ie);
    eq({tag, " R4 rd_n"}, rd_n, wr ? 1 : 0);
    eq({tag, " R4 wr_n"}, wr_n, wr ? 0 : 1);
    eq({tag, " R4 den_n"}, den_n, 0);
    eq({tag, " R4 ad_oe"}, ad_oe, wr);
    if (wr) eq({tag, " R4 ad_out"}, ad_out, wd);
    eq({tag, " R5 status"}, a_hi, status_of(seg, ie));
    eq({tag, " R10 bhe_n"}, bhe_n, !hi);
    eq({tag, " R3 ale low"}, ale, 0);
  endtask

  // Starts on a negedge in idle or T4, ends on the negedge of T4.
  task automatic run_cycle(bit boot, logic [AW-1:0] a, logic [DW-1:0] wd,
                           bit mem, bit wr, bit hi, logic [1:0] seg, bit ie,
                           int nw, logic [DW-1:0] rv, bit poke);
    if (boot) begin
      eq("R2 req_ready low before fetch", req_ready, 0);
    end else begin
      eq("R9 req_ready when offering", req_ready, 1);
      req_addr = a; req_wdata = wd; req_mem = mem; req_write = wr;
      req_hi_en = hi; req_seg = seg; req_int_en = ie; req_valid = 1'b1;
    end
    ready = 1'b1;
    ad_in = DW'($urandom);
    @(negedge clk);  // T1
    req_valid = 1'b0;
    scramble_req();
    eq(boot ? "R2 T1 ale" : "R3 T1 ale", ale, 1);
    eq("R3 T1 ad_oe", ad_oe, 1);
    eq(boot ? "R2 T1 ad_out" : "R3 T1 ad_out", ad_out, a[DW-1:0]);
    eq(boot ? "R2 T1 a_hi" : "R3 T1 a_hi", a_hi, a[AW-1:DW]);
    eq("R3 T1 mio", mio, mem);
    eq("R3 T1 dtr", dtr, wr);
    eq("R3 T1 strobes", {rd_n, wr_n, den_n}, 3'b111);
    eq("R10 T1 bhe_n", bhe_n, !hi);
    eq("R9 T1 req_ready", req_ready, 0);
    ready = (nw == 0);
    @(negedge clk);  // T2
    check_data("T2", wr, wd, hi, seg, ie);
    eq("R3 T2 mio", mio, mem);
    if (poke) begin
      req_valid = 1'b1;
      scramble_req();
    end
    for (int i = 0; i < nw; i++) begin
      @(negedge clk);  // Tw
      req_valid = 1'b0;
      check_data("R6 Tw", wr, wd, hi, seg, ie);
      eq("R6 Tw no done", done, 0);
      ready = (i == nw - 1);
    end
    @(negedge clk);  // T3
    req_valid = 1'b0;
    check_data("T3", wr, wd, hi, seg, ie);
    eq("R7 T3 no done", done, 0);
    if (!wr) ad_in = rv;
    ready = 1'($urandom);
    @(negedge clk);  // T4
    ad_in = DW'($urandom);
    if (!wr) last_rdata = rv;
    eq("R7 done in T4", done, 1);
    eq("R7 rdata", rdata, last_rdata);
    eq("R8 T4 strobes", {rd_n, wr_n, den_n, ale, ad_oe}, 5'b11100);
    eq("R5 T4 status", a_hi, status_of(seg, ie));
    eq("R10 T4 bhe_n", bhe_n, !hi);
    eq("R9 T4 req_ready", req_ready, 1);
  endtask

  task automatic idle_check(string tag);
    @(negedge clk);
    eq({tag, " R9 idle ale"}, ale, 0);
    eq({tag, " R9 idle strobes"}, {rd_n, wr_n, den_n, bhe_n, ad_oe, done}, 6'b111100);
    eq({tag, " R9 idle ready"}, req_ready, 1);
  endtask

  initial begin
    void'($urandom(32'h1B2C_3D4E));
    repeat (3) @(negedge clk);
    eq("R1 reset ale/oe/done", {ale, ad_oe, done}, 3'b000);
    eq("R1 reset strobes", {rd_n, wr_n, den_n, bhe_n}, 4'b1111);
    eq("R1 reset req_ready", req_ready, 0);
    rst = 1'b0;
    run_cycle(1'b1, 20'hFFFF0, 16'h0, 1'b1, 1'b0, 1'b1, 2'b10, 1'b0, 0, 16'hBEEF, 1'b0);
    idle_check("after fetch");
    // directed: one of each segment, waits, back-to-back, ignored request
    run_cycle(1'b0, 20'h12345, 16'h0, 1'b1, 1'b0, 1'b1, 2'b00, 1'b0, 0, 16'hA55A, 1'b0);
    run_cycle(1'b0, 20'hABCDE, 16'h7E81, 1'b0, 1'b1, 1'b0, 2'b01, 1'b1, 3, 16'h0, 1'b0);
    run_cycle(1'b0, 20'h00001, 16'h0, 1'b1, 1'b0, 1'b0, 2'b11, 1'b1, 1, 16'h0F0F, 1'b1);
    idle_check("after ignored request");
    run_cycle(1'b0, 20'hFFFFF, 16'hFFFF, 1'b0, 1'b1, 1'b1, 2'b10, 1'b0, 2, 16'h0, 1'b1);
    idle_check("after write");
    for (int k = 0; k < 60; k++) begin
      logic [AW-1:0] ra;
      logic [DW-1:0] rw, rr;
      ra = AW'($urandom);
      rw = DW'($urandom);
      rr = DW'($urandom);
      run_cycle(1'b0, ra, rw, 1'($urandom), 1'($urandom), 1'($urandom), 2'($urandom),
                1'($urandom), int'($urandom_range(0, 3)), rr, 1'($urandom));
      if ($urandom_range(0, 1) == 0) idle_check("random gap");
    end
    idle_check("final");
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule